// File: doc/BRIEF.md
# ASCII Register Command Parser

This block sits between a UART receiver and a UART transmitter running at 9600 baud, 8N1. It turns a stream of received bytes into register writes. A command is an upper-case identifier of one to three letters, an equals sign, an optionally negative decimal number and a carriage return. The block decodes the identifier against a fixed table of eighteen commands and checks the number against that command's inclusive range. A valid command produces a one-cycle write strobe carrying the register index and the signed value.

Every carriage return produces exactly one ASCII reply. The reply either acknowledges the write or gives a numeric code for the class of failure. The reply is offered one byte at a time toward the transmitter, which accepts a byte with a ready signal. Bytes that arrive while a reply is still pending wait in a small receive FIFO. If that FIFO overflows, the command being assembled is flagged. The serial link itself has no flow control.

Top module: `asc_cmd_parser`

## Requirements
- R1: A valid command raises `wr_en_o` for exactly one cycle with its index and value. The reply is the bytes 0x3E 0x4F 0x4B 0x0D (">OK" then CR), and it starts in the cycle after the strobe.
- R2: A space or any other character outside the grammar (letter, '=', optional leading '-', digits, CR) makes the command a syntax error. The reply is ">2" CR and no write happens.
- R3: Identifiers are case-sensitive. A lower-case letter gives a syntax error.
- R4: An identifier that is not in the table, or that is longer than three letters, gives ">4" CR and no write happens.
- R5: A value outside the command's inclusive range gives ">1" CR and no write happens. The ranges are: G -65..643; J, K, L 0..63; O, P 0..255; I 1..32768; M 1..4; S 0..3; the nine matrix identifiers -512..511.
- R6: Each identifier has its own index on `wr_idx_o`: G=0, J=1, K=2, L=3, O=4, P=5, I=6, M=7, S=8. The matrix identifiers follow in the order CRR, CRG, CRB, CGR, CGG, CGB, CBR, CBG, CBB, taking indices 9 to 17.
- R7: A leading '-' negates the value, and "-0" is zero. More than MAX_DIGITS digits gives a syntax error. A missing identifier or a missing value also gives a syntax error.
- R8: When a command has several faults, a syntax error outranks an unknown identifier, and an unknown identifier outranks an out-of-range value.
- R9: Bytes received while a reply is pending are kept and parsed after the reply. No write occurs while a reply is pending. If a byte is dropped because the FIFO is full, the command being assembled is answered with ">2" CR.
- R10: After every CR the parser returns to its idle state. The next command is judged independently of any earlier error.
- R11: While reset is asserted, and right after it, `tx_valid_o` and `wr_en_o` are low.
- R12: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | A received byte is present this cycle |
| rx_data_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | A reply byte is offered |
| tx_data_o | output | 8 | Reply byte |
| tx_ready_i | input | 1 | Transmitter takes the offered byte |
| wr_en_o | output | 1 | Register write strobe |
| wr_idx_o | output | 5 | Register index |
| wr_val_o | output | VAL_W | Signed register value |

## Verification
The bench builds the block with the default parameters: VAL_W of 17, MAX_DIGITS of 6 and FIFO_DEPTH of 4. With six digits, a seventh digit is easy to supply, and 999999 exceeds the 17-bit accumulator, so both the digit limit and accumulator saturation can be reached. The largest range, up to 32768, still fits the signed width. A four-entry FIFO can be filled exactly by one four-byte command. The fifth byte then overflows it, so both the buffered path and the overflow path can be reached with short directed sequences. Random commands then probe both sides of every range.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
  localparam int NUM_CMDS   = 18;
  localparam int IDX_W      = $clog2(NUM_CMDS);
  localparam int NAME_CHARS = 3;
  localparam int NAME_W     = 8 * NAME_CHARS;

  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_EQ    = 8'h3D;
  localparam logic [7:0] CH_MINUS = 8'h2D;
  localparam logic [7:0] CH_GT    = 8'h3E;

  typedef enum logic [1:0] {
    RESP_OK      = 2'd0,
    RESP_RANGE   = 2'd1,
    RESP_SYNTAX  = 2'd2,
    RESP_UNKNOWN = 2'd3
  } resp_e;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } cmd_hit_t;

  // name is right-aligned, earlier letters in higher bytes
  function automatic cmd_hit_t cmd_find(input logic [NAME_W-1:0] nm);
    cmd_hit_t r;
    r.hit = 1'b1;
    r.idx = '0;
    case (nm)
      {16'h0, "G"}: r.idx = IDX_W'(0);
      {16'h0, "J"}: r.idx = IDX_W'(1);
      {16'h0, "K"}: r.idx = IDX_W'(2);
      {16'h0, "L"}: r.idx = IDX_W'(3);
      {16'h0, "O"}: r.idx = IDX_W'(4);
      {16'h0, "P"}: r.idx = IDX_W'(5);
      {16'h0, "I"}: r.idx = IDX_W'(6);
      {16'h0, "M"}: r.idx = IDX_W'(7);
      {16'h0, "S"}: r.idx = IDX_W'(8);
      "CRR":        r.idx = IDX_W'(9);
      "CRG":        r.idx = IDX_W'(10);
      "CRB":        r.idx = IDX_W'(11);
      "CGR":        r.idx = IDX_W'(12);
      "CGG":        r.idx = IDX_W'(13);
      "CGB":        r.idx = IDX_W'(14);
      "CBR":        r.idx = IDX_W'(15);
      "CBG":        r.idx = IDX_W'(16);
      "CBB":        r.idx = IDX_W'(17);
      default:      r.hit = 1'b0;
    endcase
    return r;
  endfunction

  function automatic int cmd_lo(input logic [IDX_W-1:0] idx);
    case (int'(idx))
      0:             return -65;
      1, 2, 3, 4, 5: return 0;
      6, 7:          return 1;
      8:             return 0;
      default:       return -512;
    endcase
  endfunction

  function automatic int cmd_hi(input logic [IDX_W-1:0] idx);
    case (int'(idx))
      0:       return 643;
      1, 2, 3: return 63;
      4, 5:    return 255;
      6:       return 32768;
      7:       return 4;
      8:       return 3;
      default: return 511;
    endcase
  endfunction

  function automatic logic [7:0] resp_char(input resp_e c, input logic [1:0] pos);
    case (pos)
      2'd0: return CH_GT;
      2'd1: begin
        case (c)
          RESP_OK:     return "O";
          RESP_RANGE:  return "1";
          RESP_SYNTAX: return "2";
          default:     return "4";
        endcase
      end
      2'd2:    return (c == RESP_OK) ? 8'h4B : CH_CR;
      default: return CH_CR;
    endcase
  endfunction

  function automatic logic [1:0] resp_last(input resp_e c);
    return (c == RESP_OK) ? 2'd3 : 2'd2;
  endfunction
endpackage

// File: rtl/cmdp_fifo.sv
module cmdp_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          pop_i,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o,
  output logic          drop_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, empty, push, pop;

  assign full        = (cnt_q == CNT_W'(DEPTH));
  assign empty       = (cnt_q == '0);
  assign push        = in_valid_i && !full;
  assign pop         = pop_i && !empty;
  assign drop_o      = in_valid_i && full;
  assign out_valid_o = !empty;
  assign out_data_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_ptr_q] <= in_data_i;
  end
endmodule

// File: rtl/cmdp_range.sv
module cmdp_range
  import cmdp_pkg::*;
#(
  parameter int VAL_W = 17
) (
  input  logic [NAME_W-1:0]      name_i,
  input  logic signed [VAL_W-1:0] val_i,
  input  logic                   sat_i,
  output logic                   hit_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic                   in_range_o
);
  cmd_hit_t lk;

  always_comb begin
    lk         = cmd_find(name_i);
    hit_o      = lk.hit;
    idx_o      = lk.idx;
    in_range_o = !sat_i && (int'(val_i) >= cmd_lo(lk.idx)) && (int'(val_i) <= cmd_hi(lk.idx));
  end
endmodule

// File: rtl/cmdp_decoder.sv
module cmdp_decoder
  import cmdp_pkg::*;
#(
  parameter int VAL_W      = 17,
  parameter int MAX_DIGITS = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    byte_valid_i,
  input  logic [7:0]              byte_i,
  input  logic                    drop_i,
  output logic                    done_o,
  output resp_e                   code_o,
  output logic                    wr_en_o,
  output logic [IDX_W-1:0]        wr_idx_o,
  output logic signed [VAL_W-1:0] wr_val_o
);
  localparam int MAG_W = VAL_W - 1;
  localparam int ACC_W = MAG_W + 4;
  localparam int DIG_W = $clog2(MAX_DIGITS + 1);
  localparam int LEN_W = $clog2(NAME_CHARS + 1);

  typedef enum logic [1:0] {PS_NAME, PS_SIGN, PS_NUM} pstate_e;

  pstate_e             st_q, st_d;
  logic [NAME_W-1:0]   name_q, name_d;
  logic [LEN_W-1:0]    len_q, len_d;
  logic                long_q, long_d, syn_q, syn_d, drop_q, drop_d;
  logic                neg_q, neg_d, sat_q, sat_d;
  logic [MAG_W-1:0]    mag_q, mag_d;
  logic [DIG_W-1:0]    ndig_q, ndig_d;
  logic                done_d, wr_en_d;
  resp_e               code_d;
  logic [IDX_W-1:0]    wr_idx_d;
  logic signed [VAL_W-1:0] wr_val_d, sval;
  logic [ACC_W-1:0]    acc_c;
  logic [7:0]          dsub;
  logic                is_upper, is_digit, hit, in_rng, finish;
  logic [IDX_W-1:0]    idx;

  assign is_upper = (byte_i >= "A") && (byte_i <= "Z");
  assign is_digit = (byte_i >= "0") && (byte_i <= "9");
  assign dsub     = byte_i - 8'h30;
  assign acc_c    = ACC_W'(mag_q) * ACC_W'(10) + ACC_W'(dsub[3:0]);
  assign sval     = neg_q ? -$signed({1'b0, mag_q}) : $signed({1'b0, mag_q});

  cmdp_range #(.VAL_W(VAL_W)) range_i (
    .name_i    (name_q),
    .val_i     (sval),
    .sat_i     (sat_q),
    .hit_o     (hit),
    .idx_o     (idx),
    .in_range_o(in_rng)
  );

  always_comb begin
    st_d = st_q; name_d = name_q; len_d = len_q; long_d = long_q;
    syn_d = syn_q; drop_d = drop_q | drop_i; neg_d = neg_q;
    sat_d = sat_q; mag_d = mag_q; ndig_d = ndig_q;
    done_d = 1'b0; wr_en_d = 1'b0; code_d = code_o;
    wr_idx_d = wr_idx_o; wr_val_d = wr_val_o;
    finish = 1'b0;

    if (byte_valid_i) begin
      case (st_q)
        PS_NAME: begin
          if (is_upper) begin
            if (len_q == LEN_W'(NAME_CHARS)) long_d = 1'b1;
            else begin
              name_d = {name_q[NAME_W-9:0], byte_i};
              len_d  = len_q + 1'b1;
            end
          end else if (byte_i == CH_EQ) begin
            if (len_q == '0) syn_d = 1'b1;
            st_d = PS_SIGN;
          end else if (byte_i == CH_CR) begin
            syn_d  = 1'b1;
            finish = 1'b1;
          end else syn_d = 1'b1;
        end
        PS_SIGN, PS_NUM: begin
          if (st_q == PS_SIGN && byte_i == CH_MINUS) begin
            neg_d = 1'b1;
            st_d  = PS_NUM;
          end else if (is_digit) begin
            st_d = PS_NUM;
            if (ndig_q == DIG_W'(MAX_DIGITS)) syn_d = 1'b1;
            else begin
              ndig_d = ndig_q + 1'b1;
              if (sat_q || acc_c[ACC_W-1:MAG_W] != '0) sat_d = 1'b1;
              else mag_d = acc_c[MAG_W-1:0];
            end
          end else if (byte_i == CH_CR) begin
            if (ndig_q == '0) syn_d = 1'b1;
            finish = 1'b1;
          end else begin
            syn_d = 1'b1;
            st_d  = PS_NUM;
          end
        end
        default: st_d = PS_NAME;
      endcase
    end

    if (finish) begin
      done_d = 1'b1;
      if (syn_d || drop_d)      code_d = RESP_SYNTAX;
      else if (!hit || long_q) code_d = RESP_UNKNOWN;
      else if (!in_rng)        code_d = RESP_RANGE;
      else begin
        code_d   = RESP_OK;
        wr_en_d  = 1'b1;
        wr_idx_d = idx;
        wr_val_d = sval;
      end
      st_d = PS_NAME; name_d = '0; len_d = '0; long_d = 1'b0;
      syn_d = 1'b0; drop_d = 1'b0; neg_d = 1'b0; sat_d = 1'b0;
      mag_d = '0; ndig_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= PS_NAME; name_q <= '0; len_q <= '0; long_q <= 1'b0;
      syn_q <= 1'b0; drop_q <= 1'b0; neg_q <= 1'b0; sat_q <= 1'b0;
      mag_q <= '0; ndig_q <= '0;
      done_o <= 1'b0; code_o <= RESP_OK; wr_en_o <= 1'b0;
      wr_idx_o <= '0; wr_val_o <= '0;
    end else begin
      st_q <= st_d; name_q <= name_d; len_q <= len_d; long_q <= long_d;
      syn_q <= syn_d; drop_q <= drop_d; neg_q <= neg_d; sat_q <= sat_d;
      mag_q <= mag_d; ndig_q <= ndig_d;
      done_o <= done_d; code_o <= code_d; wr_en_o <= wr_en_d;
      wr_idx_o <= wr_idx_d; wr_val_o <= wr_val_d;
    end
  end
endmodule

// File: rtl/cmdp_resp.sv
module cmdp_resp
  import cmdp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_i,
  input  resp_e      code_i,
  output logic       busy_o,
  output logic [7:0] tx_data_o,
  input  logic       tx_ready_i
);
  resp_e      code_q;
  logic [1:0] pos_q;

  assign tx_data_o = resp_char(code_q, pos_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      code_q <= RESP_OK;
      pos_q  <= '0;
    end else if (!busy_o) begin
      if (done_i) begin
        busy_o <= 1'b1;
        code_q <= code_i;
        pos_q  <= '0;
      end
    end else if (tx_ready_i) begin
      if (pos_q == resp_last(code_q)) busy_o <= 1'b0;
      else pos_q <= pos_q + 1'b1;
    end
  end
endmodule

// File: rtl/asc_cmd_parser.sv
module asc_cmd_parser
  import cmdp_pkg::*;
#(
  parameter int VAL_W      = 17,
  parameter int MAX_DIGITS = 6,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rx_valid_i,
  input  logic [7:0]              rx_data_i,
  output logic                    tx_valid_o,
  output logic [7:0]              tx_data_o,
  input  logic                    tx_ready_i,
  output logic                    wr_en_o,
  output logic [IDX_W-1:0]        wr_idx_o,
  output logic signed [VAL_W-1:0] wr_val_o
);
  logic       fifo_valid, fifo_drop, pop, done, busy;
  logic [7:0] fifo_data;
  resp_e      code;

  // hold parsing from the finishing CR until the reply is done
  assign pop        = fifo_valid && !busy && !done;
  assign tx_valid_o = busy;

  cmdp_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (rx_valid_i),
    .in_data_i  (rx_data_i),
    .pop_i      (pop),
    .out_valid_o(fifo_valid),
    .out_data_o (fifo_data),
    .drop_o     (fifo_drop)
  );

  cmdp_decoder #(.VAL_W(VAL_W), .MAX_DIGITS(MAX_DIGITS)) dec_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_valid_i(pop),
    .byte_i      (fifo_data),
    .drop_i      (fifo_drop),
    .done_o      (done),
    .code_o      (code),
    .wr_en_o     (wr_en_o),
    .wr_idx_o    (wr_idx_o),
    .wr_val_o    (wr_val_o)
  );

  cmdp_resp resp_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done),
    .code_i    (code),
    .busy_o    (busy),
    .tx_data_o (tx_data_o),
    .tx_ready_i(tx_ready_i)
  );
endmodule

// File: rtl/cmdp_chk.sv
module cmdp_chk
  import cmdp_pkg::*;
#(
  parameter int VAL_W = 17
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    tx_valid_o,
  input logic [7:0]              tx_data_o,
  input logic                    tx_ready_i,
  input logic                    wr_en_o,
  input logic [IDX_W-1:0]        wr_idx_o,
  input logic signed [VAL_W-1:0] wr_val_o
);
  // R12
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  // R1
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  // R1
  wr_reply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> tx_valid_o && tx_data_o == CH_GT);

  // R9
  no_wr_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !wr_en_o);

  // R5
  wr_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (int'(wr_val_o) >= cmd_lo(wr_idx_o)) && (int'(wr_val_o) <= cmd_hi(wr_idx_o)));

  // R6
  wr_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> int'(wr_idx_o) < NUM_CMDS);

  // R11
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_idle_chk: assert (!tx_valid_o && !wr_en_o);
    end
  end
endmodule

bind asc_cmd_parser cmdp_chk #(.VAL_W(VAL_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_valid_o(tx_valid_o),
  .tx_data_o (tx_data_o),
  .tx_ready_i(tx_ready_i),
  .wr_en_o   (wr_en_o),
  .wr_idx_o  (wr_idx_o),
  .wr_val_o  (wr_val_o)
);

// File: tb/asc_cmd_parser_tb_top.sv
`timescale 1ns/1ps
module asc_cmd_parser_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = 8'h00;
  logic        tx_valid_o;
  logic [7:0]  tx_data_o;
  logic        tx_ready_i = 1'b0;
  logic        wr_en_o;
  logic [4:0]  wr_idx_o;
  logic signed [16:0] wr_val_o;

  int    n_vec = 0, n_fail = 0, nwr = 0, got_idx = 0, got_val = 0;
  bit    hold_rdy = 1'b0, done_flag = 1'b0;
  string resp_buf = "";

  string nm_tab [18] = '{"G","J","K","L","O","P","I","M","S",
                         "CRR","CRG","CRB","CGR","CGG","CGB","CBR","CBG","CBB"};
  int lo_tab [18] = '{-65,0,0,0,0,0,1,1,0,-512,-512,-512,-512,-512,-512,-512,-512,-512};
  int hi_tab [18] = '{643,63,63,63,255,255,32768,4,3,511,511,511,511,511,511,511,511,511};

  always #2 clk_i = ~clk_i;

  asc_cmd_parser dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i),
    .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_val_o(wr_val_o)
  );

  initial forever begin
    @(negedge clk_i);
    tx_ready_i = hold_rdy ? 1'b0 : (($urandom % 4) != 0);
  end

  always @(negedge clk_i) begin
    #1;
    if (tx_valid_o && tx_ready_i) resp_buf = $sformatf("%s%c", resp_buf, tx_data_o);
    if (wr_en_o) begin
      nwr++;
      got_idx = int'(wr_idx_o);
      got_val = int'(wr_val_o);
    end
  end

  function automatic string cmd(input string s);
    return $sformatf("%s%c", s, 8'h0d);
  endfunction

  function automatic string resp_str(input int code);
    if (code == 0) return $sformatf(">OK%c", 8'h0d);
    return $sformatf(">%0d%c", code, 8'h0d);
  endfunction

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input string act, input string exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got '%s' expected '%s'", tag, what, act, exp);
    end
  endtask

  task automatic send_str(input string s, input int gap);
    for (int i = 0; i < s.len(); i++) begin
      @(negedge clk_i);
      rx_valid_i = 1'b1;
      rx_data_i  = s[i];
      if (gap > 0) begin
        @(negedge clk_i);
        rx_valid_i = 1'b0;
        repeat (gap - 1) @(negedge clk_i);
      end
    end
    @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  task automatic wait_resp(input int n);
    int t = 0;
    while (resp_buf.len() < n && t < 600) begin
      @(negedge clk_i);
      t++;
    end
    repeat (6) @(negedge clk_i);
  endtask

  task automatic run_cmd(input string s, input int code, input int idx, input int val,
                         input string tag, input int gap);
    string exp;
    resp_buf = "";
    nwr = 0;
    send_str(cmd(s), gap);
    exp = resp_str(code);
    wait_resp(exp.len());
    check(resp_buf == exp, tag, {"reply to ", s}, resp_buf, exp);
    check(nwr == ((code == 0) ? 1 : 0), tag, {"write count for ", s},
          $sformatf("%0d", nwr), $sformatf("%0d", (code == 0) ? 1 : 0));
    if (code == 0) begin
      check(got_idx == idx, tag, {"index for ", s}, $sformatf("%0d", got_idx), $sformatf("%0d", idx));
      check(got_val == val, tag, {"value for ", s}, $sformatf("%0d", got_val), $sformatf("%0d", val));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got 'timeout' expected 'completion'");
    finish_run();
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'h5EED_0C3A));
    repeat (3) @(negedge clk_i);
    // R11
    check(!tx_valid_o && !wr_en_o, "R11", "outputs in reset",
          $sformatf("%0b%0b", tx_valid_o, wr_en_o), "00");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!tx_valid_o && !wr_en_o, "R11", "outputs after reset",
          $sformatf("%0b%0b", tx_valid_o, wr_en_o), "00");

    run_cmd("G=3", 0, 0, 3, "R1", 1);
    run_cmd("G = 3", 2, 0, 0, "R2", 1);
    run_cmd("G=3\t", 2, 0, 0, "R2", 0);
    run_cmd("g=3", 2, 0, 0, "R3", 1);
    run_cmd("Cbb=1", 2, 0, 0, "R3", 1);
    run_cmd("X=3", 4, 0, 0, "R4", 1);
    run_cmd("CRRR=1", 4, 0, 0, "R4", 1);
    run_cmd("G=1040", 1, 0, 0, "R5", 1);
    run_cmd("G=-65", 0, 0, -65, "R5", 1);
    run_cmd("G=-66", 1, 0, 0, "R5", 1);
    run_cmd("I=32768", 0, 6, 32768, "R5", 1);
    run_cmd("I=0", 1, 0, 0, "R5", 1);
    run_cmd("I=999999", 1, 0, 0, "R5", 1);
    run_cmd("CGB=-512", 0, 14, -512, "R6", 1);
    run_cmd("CBB=511", 0, 17, 511, "R6", 0);
    run_cmd("CRG=7", 0, 10, 7, "R6", 1);
    run_cmd("CBB=512", 1, 0, 0, "R6", 1);
    run_cmd("M=0000004", 2, 0, 0, "R7", 1);
    run_cmd("M=000004", 0, 7, 4, "R7", 1);
    run_cmd("P=-0", 0, 5, 0, "R7", 1);
    run_cmd("G=", 2, 0, 0, "R7", 1);
    run_cmd("=5", 2, 0, 0, "R7", 1);
    run_cmd("G=-", 2, 0, 0, "R7", 1);
    run_cmd("ZZ=9999999", 2, 0, 0, "R8", 1);
    run_cmd("ZZ=99999", 4, 0, 0, "R8", 1);
    run_cmd("G=1=2", 2, 0, 0, "R10", 1);
    run_cmd("S=3", 0, 8, 3, "R10", 1);

    // R9 buffered while reply stalled, R12 hold
    hold_rdy = 1'b1;
    resp_buf = "";
    nwr = 0;
    send_str(cmd("G=1"), 1);
    repeat (4) @(negedge clk_i);
    held = tx_data_o;
    send_str(cmd("J=7"), 0);
    repeat (4) @(negedge clk_i);
    check(tx_valid_o && tx_data_o == held && held == 8'h3E, "R12", "stalled byte",
          $sformatf("%0b/%02h", tx_valid_o, tx_data_o), "1/3e");
    hold_rdy = 1'b0;
    wait_resp(8);
    check(resp_buf == {resp_str(0), resp_str(0)}, "R9", "buffered replies",
          resp_buf, {resp_str(0), resp_str(0)});
    check(nwr == 2 && got_idx == 1 && got_val == 7, "R9", "buffered write",
          $sformatf("%0d/%0d/%0d", nwr, got_idx, got_val), "2/1/7");

    // R9 overflow: the CR of the second command is dropped
    hold_rdy = 1'b1;
    resp_buf = "";
    nwr = 0;
    send_str(cmd("G=1"), 1);
    repeat (4) @(negedge clk_i);
    send_str(cmd("G=25"), 0);
    hold_rdy = 1'b0;
    wait_resp(4);
    send_str(cmd(""), 1);
    wait_resp(7);
    check(resp_buf == {resp_str(0), resp_str(2)}, "R9", "overflow replies",
          resp_buf, {resp_str(0), resp_str(2)});
    check(nwr == 1 && got_val == 1, "R9", "overflow writes",
          $sformatf("%0d/%0d", nwr, got_val), "1/1");

    // random commands around every range edge
    for (int k = 0; k < 60; k++) begin
      int ci = int'($urandom % 18);
      int v  = lo_tab[ci] - 20 + int'($urandom % 32'(hi_tab[ci] - lo_tab[ci] + 41));
      if (k % 4 == 0) v = ($urandom % 2) ? lo_tab[ci] - int'($urandom % 2)
                                         : hi_tab[ci] + int'($urandom % 2);
      run_cmd($sformatf("%s=%0d", nm_tab[ci], v),
              (v < lo_tab[ci] || v > hi_tab[ci]) ? 1 : 0, ci, v,
              (v < lo_tab[ci] || v > hi_tab[ci]) ? "R5" : "R1", int'($urandom % 3));
    end
    finish_run();
  end
endmodule